// File: doc/BRIEF.md
# LED Keypad Refresh Sequencer

This block keeps a two-wire LED display and keypad controller up to date without software involvement. It divides an incoming prescaled tick by a programmable count. Each time the count completes, it walks a fixed script of link operations. The script loads the display memory, sets the display control byte and reads one key byte back. The electrical bit timing belongs to a separate link engine. This block hands that engine one operation at a time (bus start, write byte, read key byte, bus stop) and waits for a done pulse before it moves on.

The display bytes and the four brightness bits are sampled when a refresh cycle starts, so a cycle always sends one consistent picture. The returned key byte is shown on `key_code_o` together with a one-clock `key_valid_o` strobe. A zero read-back is mapped to a fixed no-key code. The engine can report that a written byte was not acknowledged. In that case the block closes the bus with a stop, abandons the rest of the cycle and sets a sticky error flag. Ticks that complete a count while a cycle is still running are kept as a single pending request.

Top module: `ledkey_refresh_seq`

## Requirements
- R1: While `rst_ni` is low, `lnk_valid_o`, `key_valid_o` and `err_o` are 0 and `key_code_o` is 8'h00.
- R2: Every TICK_DIV-th clock edge that samples `tick_i` high completes a count, and the count restarts. If the block is idle, `lnk_valid_o` rises after the second clock edge that follows the completing edge. It stays high until the cycle's last operation is done.
- R3: Operation codes on `lnk_op_o` are 0 = bus start, 1 = write byte, 2 = read key byte, 3 = bus stop. A cycle opens with start, write 8'h40 (auto-increment data write), stop.
- R4: It continues with start, write 8'hC0 (address zero), then NUM_DIGITS writes of the display bytes, lowest byte `disp_data_i[7:0]` first, then stop. The display bytes are those sampled on the edge that started the cycle.
- R5: It continues with start, write {4'h8, bright}, stop. Here bright is the value of `bright_i` sampled at cycle start, with bit 3 the display-on bit and bits 2:0 the level.
- R6: It ends with start, write 8'h42, read key byte, stop, and the block then returns to idle.
- R7: While `lnk_valid_o` is high and `lnk_done_i` is low, `lnk_op_o` and `lnk_data_o` hold their values. Each edge with `lnk_done_i` high consumes exactly one operation. `lnk_data_o` is 0 for non-write operations.
- R8: On the edge that completes a read operation, `key_code_o` takes `lnk_rdata_i`, or 8'h30 (NO_KEY_CODE) if that byte is zero. `key_valid_o` is high for exactly the following clock cycle. At all other times `key_code_o` holds its value.
- R9: A count completed while a cycle is running starts one new cycle after the current one ends. Several such completions still start only one cycle.
- R10: A write operation completed with `lnk_ack_err_i` high makes the next operation a stop, after which the block goes idle. `err_o` then stays 1 until reset, and the key output is not updated.
- R11: `lnk_ack_err_i` has no effect when it comes with the done of a start, stop or read operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled timer tick, one clock wide |
| disp_data_i | input | NUM_DIGITS*8 | Display bytes, byte 0 in the low bits |
| bright_i | input | 4 | Display-on bit (3) and brightness level (2:0) |
| lnk_valid_o | output | 1 | An operation is presented to the link engine |
| lnk_op_o | output | 2 | Operation code |
| lnk_data_o | output | 8 | Byte to write |
| lnk_done_i | input | 1 | Link engine has finished the current operation |
| lnk_ack_err_i | input | 1 | Written byte was not acknowledged |
| lnk_rdata_i | input | 8 | Key byte returned by a read operation |
| key_code_o | output | 8 | Last key code |
| key_valid_o | output | 1 | One-clock strobe on key code update |
| err_o | output | 1 | Sticky acknowledge failure flag |

## Verification
The bench checks start timing against ticks that arrive every clock and against a slow link. In that mix several counts complete during one cycle. A design that counted pending requests instead of collapsing them would run extra cycles, and one that dropped them would stall. A missing-acknowledge is injected on every fifth write, including the address and key-command bytes. A design that kept going, skipped the closing stop or updated the key would leave the expected operation stream at once. Spurious acknowledge errors are raised on start, stop and read completions to catch a design that aborts on any of them. Zero and non-zero key bytes alternate, which exposes a wrong no-key mapping or a stretched strobe.

// File: rtl/ledkey_pkg.sv
package ledkey_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } link_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_ABORT = 2'd2
  } seq_state_e;

  localparam logic [7:0] CMD_WR_AUTO   = 8'h40;
  localparam logic [7:0] CMD_ADDR0     = 8'hC0;
  localparam logic [7:0] CMD_CTRL_BASE = 8'h80;
  localparam logic [7:0] CMD_KEY_RD    = 8'h42;

  // fixed ops around the display bytes
  localparam int unsigned SCRIPT_FIXED = 13;

endpackage

// File: rtl/ledkey_tick_div.sv
module ledkey_tick_div #(
  parameter int unsigned TICK_DIV = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic fire_o
);

  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fire_o <= 1'b0;
    end else begin
      fire_o <= 1'b0;
      if (tick_i) begin
        if (cnt_q == CNT_MAX) begin
          cnt_q  <= '0;
          fire_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R2
  fire_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |-> $past(tick_i));

endmodule

// File: rtl/ledkey_script.sv
module ledkey_script
  import ledkey_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  parameter int unsigned IW         = 5
) (
  input  logic [IW-1:0]           idx_i,
  input  logic [NUM_DIGITS*8-1:0] disp_i,
  input  logic [3:0]              bright_i,
  output link_op_e                op_o,
  output logic [7:0]              data_o,
  output logic                    last_o
);

  localparam int unsigned N    = NUM_DIGITS;
  localparam int unsigned LAST = SCRIPT_FIXED + N - 1;

  int pos;

  always_comb begin
    pos    = int'(idx_i);
    op_o   = OP_WRITE;
    data_o = '0;
    if (pos == 0 || pos == 3 || pos == 6 + N || pos == 9 + N) begin
      op_o = OP_START;
    end else if (pos == 2 || pos == 5 + N || pos == 8 + N || pos == 12 + N) begin
      op_o = OP_STOP;
    end else if (pos == 11 + N) begin
      op_o = OP_READ;
    end else begin
      if (pos == 1)      data_o = CMD_WR_AUTO;
      if (pos == 4)      data_o = CMD_ADDR0;
      if (pos == 7 + N)  data_o = CMD_CTRL_BASE | {4'h0, bright_i};
      if (pos == 10 + N) data_o = CMD_KEY_RD;
      for (int k = 0; k < N; k++) begin
        if (pos == 5 + k) data_o = disp_i[k*8 +: 8];
      end
    end
  end

  assign last_o = (idx_i == IW'(LAST));

endmodule

// File: rtl/ledkey_key_capture.sv
module ledkey_key_capture #(
  parameter logic [7:0] NO_KEY_CODE = 8'h30
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cap_i,
  input  logic [7:0] rdata_i,
  output logic [7:0] key_code_o,
  output logic       key_valid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_code_o  <= '0;
      key_valid_o <= 1'b0;
    end else begin
      key_valid_o <= cap_i;
      if (cap_i) key_code_o <= (rdata_i == 8'h00) ? NO_KEY_CODE : rdata_i;
    end
  end

  // R8
  key_strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |=> !key_valid_o);

  // R8
  key_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_valid_o |-> $stable(key_code_o));

endmodule

// File: rtl/ledkey_refresh_seq.sv
module ledkey_refresh_seq
  import ledkey_pkg::*;
#(
  parameter int unsigned NUM_DIGITS  = 4,
  parameter int unsigned TICK_DIV    = 20,
  parameter logic [7:0]  NO_KEY_CODE = 8'h30
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic [NUM_DIGITS*8-1:0] disp_data_i,
  input  logic [3:0]              bright_i,
  output logic                    lnk_valid_o,
  output logic [1:0]              lnk_op_o,
  output logic [7:0]              lnk_data_o,
  input  logic                    lnk_done_i,
  input  logic                    lnk_ack_err_i,
  input  logic [7:0]              lnk_rdata_i,
  output logic [7:0]              key_code_o,
  output logic                    key_valid_o,
  output logic                    err_o
);

  localparam int unsigned NOPS = SCRIPT_FIXED + NUM_DIGITS;
  localparam int unsigned IW   = $clog2(NOPS);

  seq_state_e              state_q;
  logic [IW-1:0]           idx_q;
  logic                    pend_q;
  logic [NUM_DIGITS*8-1:0] disp_snap_q;
  logic [3:0]              bright_snap_q;
  logic                    fire;
  logic                    start;
  link_op_e                rom_op;
  logic [7:0]              rom_data;
  logic                    rom_last;
  link_op_e                cur_op;
  logic                    wr_fail;
  logic                    rd_done;

  ledkey_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .fire_o (fire)
  );

  ledkey_script #(.NUM_DIGITS(NUM_DIGITS), .IW(IW)) u_script (
    .idx_i    (idx_q),
    .disp_i   (disp_snap_q),
    .bright_i (bright_snap_q),
    .op_o     (rom_op),
    .data_o   (rom_data),
    .last_o   (rom_last)
  );

  assign start   = (state_q == ST_IDLE) && pend_q;
  assign cur_op  = (state_q == ST_ABORT) ? OP_STOP : rom_op;
  assign wr_fail = (state_q == ST_RUN) && lnk_done_i && (rom_op == OP_WRITE) && lnk_ack_err_i;
  assign rd_done = (state_q == ST_RUN) && lnk_done_i && (rom_op == OP_READ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      idx_q         <= '0;
      pend_q        <= 1'b0;
      disp_snap_q   <= '0;
      bright_snap_q <= '0;
      err_o         <= 1'b0;
    end else begin
      // completions while busy collapse into one request
      pend_q <= (pend_q && !start) || fire;
      if (wr_fail) err_o <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q       <= ST_RUN;
            idx_q         <= '0;
            disp_snap_q   <= disp_data_i;
            bright_snap_q <= bright_i;
          end
        end
        ST_RUN: begin
          if (lnk_done_i) begin
            if (wr_fail) begin
              state_q <= ST_ABORT;
            end else if (rom_last) begin
              state_q <= ST_IDLE;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_ABORT: begin
          if (lnk_done_i) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign lnk_valid_o = (state_q != ST_IDLE);
  assign lnk_op_o    = cur_op;
  assign lnk_data_o  = (state_q == ST_ABORT) ? 8'h00 : rom_data;

  ledkey_key_capture #(.NO_KEY_CODE(NO_KEY_CODE)) u_key (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (rd_done),
    .rdata_i     (lnk_rdata_i),
    .key_code_o  (key_code_o),
    .key_valid_o (key_valid_o)
  );

  // R7
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lnk_valid_o && !lnk_done_i) |=> (lnk_valid_o && $stable(lnk_op_o) && $stable(lnk_data_o)));

  // R10
  abort_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lnk_valid_o && lnk_done_i && lnk_ack_err_i && lnk_op_o == 2'd1) |=> (lnk_valid_o && lnk_op_o == 2'd3));

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R6
  stop_ends_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lnk_valid_o && lnk_done_i && lnk_op_o == 2'd3 && (state_q == ST_ABORT || rom_last)) |=> !lnk_valid_o);

  // R7
  nonwrite_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lnk_valid_o && lnk_op_o != 2'd1) |-> (lnk_data_o == 8'h00));

endmodule

// File: tb/ledkey_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module ledkey_refresh_seq_tb_top;
  import ledkey_pkg::*;

  localparam int N   = 4;
  localparam int DIV = 20;
  localparam logic [7:0] NOKEY = 8'h30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [N*8-1:0] disp = 32'h3F065B4F;
  logic [3:0] bright = 4'hF;
  logic done = 1'b0, ackerr = 1'b0;
  logic [7:0] rdata = 8'h00;
  logic lvalid, kvalid, err;
  logic [1:0] lop;
  logic [7:0] ldata, kcode;

  always #2.5 clk = ~clk;

  ledkey_refresh_seq #(.NUM_DIGITS(N), .TICK_DIV(DIV), .NO_KEY_CODE(NOKEY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .disp_data_i(disp), .bright_i(bright),
    .lnk_valid_o(lvalid), .lnk_op_o(lop), .lnk_data_o(ldata), .lnk_done_i(done),
    .lnk_ack_err_i(ackerr), .lnk_rdata_i(rdata), .key_code_o(kcode),
    .key_valid_o(kvalid), .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // expected operation stream
  logic [1:0] q_op[$];
  logic [7:0] q_dat[$];
  string      q_req[$];

  task automatic push(logic [1:0] op, logic [7:0] d, string req);
    q_op.push_back(op); q_dat.push_back(d); q_req.push_back(req);
  endtask

  task automatic pop();
    void'(q_op.pop_front()); void'(q_dat.pop_front()); void'(q_req.pop_front());
  endtask

  int m_cnt = 0;
  bit m_fire = 0, m_pend = 0, m_err = 0, exp_kv = 0;
  logic [7:0] m_code = 8'h00;

  int tick_per = 0, tick_ph = 0, dly = 0, wr_cnt = 0, err_every = 0, kcnt = 0;
  bit slow = 0, noise = 0;

  // start model at the active edge (R2, R9)
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_fire = 0; m_pend = 0;
    end else begin
      bit st;
      st = (q_op.size() == 0) && !done && m_pend;
      if (st) begin
        push(OP_START, 8'h00, "R3"); push(OP_WRITE, 8'h40, "R3"); push(OP_STOP, 8'h00, "R3");
        push(OP_START, 8'h00, "R4"); push(OP_WRITE, 8'hC0, "R4");
        for (int k = 0; k < N; k++) push(OP_WRITE, disp[k*8 +: 8], "R4");
        push(OP_STOP, 8'h00, "R4");
        push(OP_START, 8'h00, "R5"); push(OP_WRITE, {4'h8, bright}, "R5"); push(OP_STOP, 8'h00, "R5");
        push(OP_START, 8'h00, "R6"); push(OP_WRITE, 8'h42, "R6");
        push(OP_READ, 8'h00, "R6"); push(OP_STOP, 8'h00, "R6");
      end
      m_pend = (m_pend && !st) || m_fire;
      m_fire = tick && (m_cnt == DIV - 1);
      if (tick) m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
    end
  end

  // compare, then drive the link model and ticks
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(lvalid == (q_op.size() > 0), "R2", lvalid, q_op.size() > 0);
      if (q_op.size() > 0)
        chk(lop == q_op[0] && ldata == q_dat[0], q_req[0], {lop, ldata}, {q_op[0], q_dat[0]});
      if (exp_kv) chk(kvalid && kcode == m_code, "R8", {kvalid, kcode}, {1'b1, m_code});
      else        chk(!kvalid && kcode == m_code, "R8", {kvalid, kcode}, {1'b0, m_code});
      chk(err == m_err, "R10", err, m_err);
      exp_kv = 0;
      done = 0; ackerr = 0; rdata = 8'($urandom);
      if (lvalid && q_op.size() > 0) begin
        if (dly > 0) dly--;
        else begin
          done = 1;
          dly = slow ? int'($urandom_range(4, 0)) : 0;
          if (q_op[0] == OP_WRITE) begin
            wr_cnt++;
            if (err_every > 0 && wr_cnt % err_every == 0) begin
              ackerr = 1; m_err = 1;
              q_op.delete(); q_dat.delete(); q_req.delete();
              push(OP_STOP, 8'h00, "R10");
            end else pop();
          end else if (q_op[0] == OP_READ) begin
            kcnt++;
            rdata = (kcnt % 2 == 0) ? 8'h00 : {kcnt[6:0], 1'b1};
            m_code = (rdata == 8'h00) ? NOKEY : rdata;
            exp_kv = 1;
            ackerr = noise ? 1'($urandom) : 1'b0;  // R11
            pop();
          end else begin
            ackerr = noise ? 1'($urandom) : 1'b0;  // R11
            pop();
          end
        end
      end
      if (tick_per > 0) begin
        tick_ph++;
        tick = (tick_ph % tick_per == 0);
      end else tick = 0;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1
    chk(!lvalid && !kvalid && !err && kcode == 8'h00, "R1", {lvalid, kvalid, err, kcode}, 0);
    @(negedge clk);
    chk(!lvalid && !kvalid && !err && kcode == 8'h00, "R1", {lvalid, kvalid, err, kcode}, 0);
    rst_n = 1;
    tick_per = 2;
    repeat (700) @(negedge clk);
    tick_per = 1; slow = 1; noise = 1;
    for (int p = 0; p < 6; p++) begin
      disp = $urandom;
      bright = 4'($urandom);
      repeat (300) @(negedge clk);
    end
    err_every = 5;
    repeat (900) @(negedge clk);
    tick_per = 0; err_every = 0; slow = 0;
    repeat (300) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

endmodule